// File: doc/BRIEF.md
# Adaptive Link Setting Search Controller

This controller hunts for a transmitter and receiver setting that yields a clean serial link. It drives three 4-bit codes: a pre-cursor emphasis tap, a first post-cursor emphasis tap and a receiver equalizer code. It walks through candidate combinations of these codes. For each candidate it applies the codes and lets the analog path settle. It then pulses a clear to the pattern checker and watches the checker's error count over a fixed measurement window.

The search stops at the first candidate that shows zero errors while the checker is locked. If no candidate is clean, the controller leaves applied the candidate with the fewest errors and flags failure. A stop request ends the search early and applies the best candidate measured so far. The error figures only mean something when the transmit path is looped back into the receive path that feeds the checker.

Three sweep modes exist. The joint mode sweeps all three codes. The equalizer mode sweeps only the receiver code. The emphasis mode sweeps only the two emphasis taps.

Top module: `eq_search_ctrl`

## Requirements
- R1: After reset, busy, done, fail and chk_clear are low and all three codes are zero.
- R2: Joint mode (mode 2'b00) tries settings in ascending order of the concatenation {pre_tap, post_tap, eq_code}, with the equalizer code changing fastest. Each candidate takes SETTLE_CYC+1+WINDOW_CYC cycles of busy.
- R3: Equalizer mode (mode 2'b01) holds both emphasis taps at zero and steps eq_code upward from zero through its largest value.
- R4: Emphasis mode (mode 2'b10) holds eq_code at zero and steps {pre_tap, post_tap} upward from zero, with post_tap changing fastest.
- R5: A candidate's codes are held for SETTLE_CYC cycles. Then chk_clear is high for exactly one cycle with the codes unchanged. Then the error count is sampled in the last of the following WINDOW_CYC cycles.
- R6: A candidate passes when chk_synced is high and err_count is zero at the sample. The search then ends with done high and that candidate's codes kept.
- R7: If no candidate passes, the search ends with fail high and applies the candidate with the lowest error figure. On a tie, the earlier candidate wins.
- R8: A candidate whose checker is not synced at the sample counts as having the all-ones error value, whatever err_count shows.
- R9: A stop pulse while busy ends the search on the next edge. It applies the best candidate completed so far, or the first candidate if none has completed, and raises fail.
- R10: start is ignored while busy. Mode 2'b11 behaves as joint mode. The mode is captured when the search starts.
- R11: At most one of busy, done and fail is high at any time. A new start clears done and fail. Outside a search, the codes and the status stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (sampled only when idle) |
| abort | input | 1 | Stop a running search |
| mode | input | 2 | 00 joint, 01 equalizer only, 10 emphasis only, 11 joint |
| err_count | input | ERR_W | Error count from the pattern checker |
| chk_synced | input | 1 | Pattern checker lock indication |
| chk_clear | output | 1 | One-cycle clear to the pattern checker |
| pre_tap | output | CODE_W | Applied pre-cursor emphasis code |
| post_tap | output | CODE_W | Applied first post-cursor emphasis code |
| eq_code | output | CODE_W | Applied receiver equalizer code |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search found a clean setting |
| fail | output | 1 | No clean setting, or search stopped |

## Verification
The assertions assume that start and abort are synchronous to clk. They also assume that err_count and chk_synced are functions of the applied codes, stable whenever those codes are stable. The bench drives both checker inputs from tables indexed by the codes present at the ports, so this always holds. It changes the tables only while the controller is idle. Stop and restart pulses are placed inside a settling interval, never on a measurement-end cycle, which keeps the expected best-so-far unambiguous.

// File: rtl/eqs_pkg.sv
package eqs_pkg;
  typedef enum logic [1:0] {
    SRCH_JOINT     = 2'b00,
    SRCH_EQ        = 2'b01,
    SRCH_TAPS      = 2'b10,
    SRCH_JOINT_ALT = 2'b11
  } srch_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SETTLE = 2'b01,
    ST_CLEAR  = 2'b10,
    ST_MEAS   = 2'b11
  } srch_state_e;
endpackage

// File: rtl/eqs_cand_gen.sv
module eqs_cand_gen
  import eqs_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  srch_mode_e              sweep_mode,
  input  logic [3*CODE_W-1:0]     cand_idx,
  output logic [3*CODE_W-1:0]     cand_set,
  output logic                    sweep_wrap
);
  localparam int C = CODE_W;

  logic [C-1:0] pre_c, post_c, eq_c;

  always_comb begin
    pre_c      = '0;
    post_c     = '0;
    eq_c       = '0;
    sweep_wrap = 1'b0;
    case (sweep_mode)
      SRCH_EQ: begin
        eq_c       = cand_idx[C-1:0];
        sweep_wrap = (cand_idx[C-1:0] == '0);
      end
      SRCH_TAPS: begin
        pre_c      = cand_idx[2*C-1:C];
        post_c     = cand_idx[C-1:0];
        sweep_wrap = (cand_idx[2*C-1:0] == '0);
      end
      default: begin
        pre_c      = cand_idx[3*C-1:2*C];
        post_c     = cand_idx[2*C-1:C];
        eq_c       = cand_idx[C-1:0];
        sweep_wrap = (cand_idx == '0);
      end
    endcase
  end

  assign cand_set = {pre_c, post_c, eq_c};
endmodule

// File: rtl/eqs_interval_cnt.sv
module eqs_interval_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (restart)        count <= '0;
    else if (count != '1)    count <= count + 1'b1;
  end
endmodule

// File: rtl/eqs_best_track.sv
module eqs_best_track #(
  parameter int SET_W = 12,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [SET_W-1:0] init_set,
  input  logic             sample,
  input  logic [SET_W-1:0] sample_set,
  input  logic [ERR_W-1:0] sample_err,
  output logic [SET_W-1:0] best_set,
  output logic [SET_W-1:0] pick_set
);
  logic [ERR_W-1:0] best_err;
  logic             better;

  assign better   = sample && (sample_err < best_err);
  assign pick_set = better ? sample_set : best_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_set <= '0;
      best_err <= '1;
    end else if (init) begin
      best_set <= init_set;
      best_err <= '1;
    end else if (better) begin
      best_set <= sample_set;
      best_err <= sample_err;
    end
  end
endmodule

// File: rtl/eq_search_ctrl.sv
module eq_search_ctrl
  import eqs_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int ERR_W      = 16,
  parameter int SETTLE_CYC = 64,
  parameter int WINDOW_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [1:0]        mode,
  input  logic [ERR_W-1:0]  err_count,
  input  logic              chk_synced,
  output logic              chk_clear,
  output logic [CODE_W-1:0] pre_tap,
  output logic [CODE_W-1:0] post_tap,
  output logic [CODE_W-1:0] eq_code,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  localparam int SET_W   = 3 * CODE_W;
  localparam int TMR_MAX = (SETTLE_CYC > WINDOW_CYC) ? SETTLE_CYC : WINDOW_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  srch_state_e       state_q;
  srch_mode_e        mode_q;
  logic [SET_W-1:0]  idx_q;
  logic [SET_W-1:0]  applied_q;
  logic              done_q, fail_q;

  srch_mode_e        gen_mode;
  logic [SET_W-1:0]  gen_idx, next_set, best_set, pick_set;
  logic              next_wrap;
  logic [TMR_W-1:0]  tmr;
  logic              tmr_restart;
  logic [ERR_W-1:0]  eff_err;
  logic              idle, launch, settle_end, meas_end, clean, stop;

  assign idle       = (state_q == ST_IDLE);
  assign launch     = idle && start;
  assign stop       = !idle && abort;
  assign settle_end = (state_q == ST_SETTLE) && (tmr == TMR_W'(SETTLE_CYC - 1));
  assign meas_end   = (state_q == ST_MEAS) && (tmr == TMR_W'(WINDOW_CYC - 1)) && !abort;
  assign eff_err    = chk_synced ? err_count : '1;
  assign clean      = (eff_err == '0);

  assign gen_mode = idle ? srch_mode_e'(mode) : mode_q;
  assign gen_idx  = idle ? '0 : idx_q + 1'b1;

  eqs_cand_gen #(.CODE_W(CODE_W)) u_cand (
    .sweep_mode (gen_mode),
    .cand_idx   (gen_idx),
    .cand_set   (next_set),
    .sweep_wrap (next_wrap)
  );

  assign tmr_restart = launch || (state_q == ST_CLEAR) ||
                       (meas_end && !clean && !next_wrap);

  eqs_interval_cnt #(.CNT_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .count   (tmr)
  );

  eqs_best_track #(.SET_W(SET_W), .ERR_W(ERR_W)) u_best (
    .clk        (clk),
    .rst_n      (rst_n),
    .init       (launch),
    .init_set   (next_set),
    .sample     (meas_end),
    .sample_set (applied_q),
    .sample_err (eff_err),
    .best_set   (best_set),
    .pick_set   (pick_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= SRCH_JOINT;
      idx_q     <= '0;
      applied_q <= '0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else if (launch) begin
      state_q   <= ST_SETTLE;
      mode_q    <= srch_mode_e'(mode);
      idx_q     <= '0;
      applied_q <= next_set;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else if (stop) begin
      state_q   <= ST_IDLE;
      applied_q <= best_set;
      fail_q    <= 1'b1;
    end else begin
      case (state_q)
        ST_SETTLE: if (settle_end) state_q <= ST_CLEAR;
        ST_CLEAR:  state_q <= ST_MEAS;
        ST_MEAS: begin
          if (meas_end) begin
            if (clean) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else if (next_wrap) begin
              state_q   <= ST_IDLE;
              applied_q <= pick_set;
              fail_q    <= 1'b1;
            end else begin
              state_q   <= ST_SETTLE;
              idx_q     <= gen_idx;
              applied_q <= next_set;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign chk_clear = (state_q == ST_CLEAR);
  assign busy      = !idle;
  assign done      = done_q;
  assign fail      = fail_q;
  assign pre_tap   = applied_q[SET_W-1:2*CODE_W];
  assign post_tap  = applied_q[2*CODE_W-1:CODE_W];
  assign eq_code   = applied_q[CODE_W-1:0];
endmodule

// File: rtl/eq_search_ctrl_chk.sv
module eq_search_ctrl_chk
  import eqs_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              abort,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              chk_clear,
  input logic [CODE_W-1:0] pre_tap,
  input logic [CODE_W-1:0] post_tap,
  input logic [CODE_W-1:0] eq_code,
  input srch_mode_e        mode_q
);
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, fail})); // R11

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_clear |=> !chk_clear); // R5

  AST_CLEAR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    chk_clear |-> busy); // R5

  AST_CODES_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    chk_clear |-> $stable({pre_tap, post_tap, eq_code})); // R5

  AST_EQ_MODE_TAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == SRCH_EQ) |-> (pre_tap == '0 && post_tap == '0)); // R3

  AST_TAP_MODE_EQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == SRCH_TAPS) |-> (eq_code == '0)); // R4

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> (!busy && fail)); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({pre_tap, post_tap, eq_code, done, fail})); // R11
endmodule

bind eq_search_ctrl eq_search_ctrl_chk #(.CODE_W(CODE_W)) u_eqs_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .abort     (abort),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .chk_clear (chk_clear),
  .pre_tap   (pre_tap),
  .post_tap  (post_tap),
  .eq_code   (eq_code),
  .mode_q    (mode_q)
);

// File: tb/test_eq_search_ctrl.sv
`timescale 1ns/1ps
module test_eq_search_ctrl;
  localparam int CW  = 2;
  localparam int EW  = 8;
  localparam int SC  = 3;
  localparam int WC  = 5;
  localparam int PER = SC + 1 + WC;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [EW-1:0] err_count;
  logic chk_synced, chk_clear, busy, done, fail;
  logic [CW-1:0] pre_tap, post_tap, eq_code;

  logic [EW-1:0] errs [64];
  logic          sync [64];

  int checks = 0, errors = 0;
  int cyc, order_bad, stat_bad;

  always #4 clk = ~clk;

  assign err_count  = errs[{pre_tap, post_tap, eq_code}];
  assign chk_synced = sync[{pre_tap, post_tap, eq_code}];

  eq_search_ctrl #(.CODE_W(CW), .ERR_W(EW), .SETTLE_CYC(SC), .WINDOW_CYC(WC)) i_eq_search_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .mode(mode),
    .err_count(err_count), .chk_synced(chk_synced), .chk_clear(chk_clear),
    .pre_tap(pre_tap), .post_tap(post_tap), .eq_code(eq_code),
    .busy(busy), .done(done), .fail(fail));

  function automatic logic [5:0] cand(input logic [1:0] m, input int i);
    logic [5:0] v = 6'(i);
    case (m)
      2'b01:   return {4'b0000, v[1:0]};
      2'b10:   return {v[3:2], v[1:0], 2'b00};
      default: return v;
    endcase
  endfunction

  function automatic int ncand(input logic [1:0] m);
    return (m == 2'b01) ? 4 : (m == 2'b10) ? 16 : 64;
  endfunction

  function automatic int eff(input logic [5:0] s);
    return sync[s] ? int'(errs[s]) : 255;
  endfunction

  // Predict outcome over the first lim candidates: pass flag, setting, candidates tried
  task automatic predict(input logic [1:0] m, input int lim,
                         output bit pass, output logic [5:0] set, output int n);
    int best = 255;
    pass = 1'b0; set = cand(m, 0); n = lim;
    for (int i = 0; i < lim; i++) begin
      if (eff(cand(m, i)) == 0) begin
        pass = 1'b1; set = cand(m, i); n = i + 1; return;
      end
      if (eff(cand(m, i)) < best) begin
        best = eff(cand(m, i)); set = cand(m, i);
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill(input int lo, input int span, input int unsync_mod);
    for (int s = 0; s < 64; s++) begin
      errs[s] = EW'(lo + ($urandom % span));
      sync[s] = (unsync_mod == 0) ? 1'b1 : (($urandom % unsync_mod) != 0);
    end
  endtask

  // Launch a search; abort_at / restart_at are busy-cycle numbers (-1 for none)
  task automatic run(input logic [1:0] m, input int abort_at, input int restart_at);
    int k = 0;
    logic [1:0] me = (m == 2'b11) ? 2'b00 : m;
    @(negedge clk); start = 1'b1; mode = m;
    @(negedge clk); start = 1'b0; mode = ~m;
    cyc = 0; order_bad = 0; stat_bad = 0;
    while (busy && cyc < 2000) begin
      cyc++;
      if (done || fail) stat_bad++;
      if (chk_clear) begin
        if ({pre_tap, post_tap, eq_code} != cand(me, k) || cyc != k * PER + SC + 1) order_bad++;
        k++;
      end
      abort = (cyc == abort_at);
      start = (cyc == restart_at);
      if (cyc == restart_at) mode = 2'b01;
      @(negedge clk);
    end
    abort = 1'b0; start = 1'b0;
  endtask

  task automatic check_result(input string req, input bit pass, input logic [5:0] set, input int n);
    chk(done == pass && fail == !pass && !busy, req, "status done", int'(done), int'(pass));
    chk({pre_tap, post_tap, eq_code} == set, req, "final codes", int'({pre_tap, post_tap, eq_code}), int'(set));
    chk(cyc == n * PER, req, "busy cycles", cyc, n * PER);
    chk(order_bad == 0, req, "candidate order/clear timing", order_bad, 0);
    chk(stat_bad == 0, "R11", "status cleared while busy", stat_bad, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit p; logic [5:0] s; int n;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) begin errs[i] = 8'd1; sync[i] = 1'b1; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !fail && !chk_clear, "R1", "status after reset", int'({busy, done, fail, chk_clear}), 0);
    chk({pre_tap, post_tap, eq_code} == 6'd0, "R1", "codes after reset", int'({pre_tap, post_tap, eq_code}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail, "R1", "idle after release", int'({busy, done, fail}), 0);

    // R2 R6: joint search, clean setting at candidate 37
    fill(1, 200, 0);
    errs[cand(2'b00, 37)] = 0;
    predict(2'b00, 64, p, s, n);
    run(2'b00, -1, -1);
    check_result("R6", p, s, n);

    // R7 R8: no clean setting, a tie, and an unsynced zero-error setting
    fill(4, 200, 0);
    errs[10] = 0; sync[10] = 1'b0;
    errs[20] = 3; errs[50] = 3;
    run(2'b00, -1, -1);
    check_result("R7", 1'b0, 6'd20, 64);
    chk(fail && {pre_tap, post_tap, eq_code} != 6'd10, "R8", "unsynced zero not chosen", int'({pre_tap, post_tap, eq_code}), 20);

    // R3: equalizer-only sweep, clean setting exists only off the sweep
    fill(60, 100, 0);
    errs[6'b000000] = 50; errs[6'b000001] = 40; errs[6'b000010] = 7; errs[6'b000011] = 30;
    errs[6'b010000] = 0;
    run(2'b01, -1, -1);
    check_result("R3", 1'b0, 6'b000010, 4);

    // R4: emphasis-only sweep, zero at eq!=0 must be unreachable
    fill(1, 200, 0);
    for (int i = 0; i < 16; i++) errs[{i[3:0], 2'b01}] = 0;
    errs[{2'd2, 2'd1, 2'd0}] = 0;
    run(2'b10, -1, -1);
    check_result("R4", 1'b1, {2'd2, 2'd1, 2'd0}, 10);

    // R9: stop inside candidate 5's settle interval
    fill(1, 200, 4);
    predict(2'b00, 5, p, s, n);
    run(2'b00, 5 * PER + 2, -1);
    chk(fail && !done && !busy, "R9", "status after stop", int'({busy, done, fail}), 1);
    chk({pre_tap, post_tap, eq_code} == s, "R9", "best so far applied", int'({pre_tap, post_tap, eq_code}), int'(s));
    chk(cyc == 5 * PER + 2, "R9", "stop latency", cyc, 5 * PER + 2);

    // R10: restart while busy ignored
    fill(1, 200, 0);
    errs[cand(2'b00, 12)] = 0;
    run(2'b00, -1, 30);
    check_result("R10", 1'b1, cand(2'b00, 12), 13);

    // R10: mode 3 behaves as joint
    fill(1, 200, 0);
    errs[cand(2'b00, 5)] = 0;
    run(2'b11, -1, -1);
    check_result("R10", 1'b1, cand(2'b00, 5), 6);

    // R2 R6 R7: random tables and modes
    for (int it = 0; it < 10; it++) begin
      logic [1:0] m = 2'($urandom % 4);
      fill(1, 40, 5);
      if (($urandom % 2) == 0) errs[6'($urandom % 64)] = 0;
      predict((m == 2'b11) ? 2'b00 : m, ncand(m), p, s, n);
      run(m, -1, -1);
      check_result(p ? "R6" : "R7", p, s, n);
      chk(cyc == n * PER, "R2", "random run length", cyc, n * PER);
    end

    // R11: idle outputs stay put
    s = {pre_tap, post_tap, eq_code};
    repeat (5) @(negedge clk);
    chk({pre_tap, post_tap, eq_code} == s && !busy, "R11", "idle hold", int'({pre_tap, post_tap, eq_code}), int'(s));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule